// File: doc/BRIEF.md
# UART Receive Interrupt Identifier

This block sits beside the receive FIFO of a 16550-style serial port and decides which receive-side interrupt is pending. Its inputs are the FIFO occupancy, the programmed trigger level, the error flags of the character at the head of the FIFO, the FIFO and per-source enables, and a pending flag from a separate character-timeout detector. From these it produces an 8-bit identification code, a level interrupt line to the processor, a one-cycle pulse that marks a change of the code, and the data-ready status bit.

The identification code and the interrupt line are combinational in the inputs. A change in the condition therefore shows up at the ports in the same cycle. Only two things are registered: the code held at the last clock edge, which the change pulse is compared against, and the data-ready bit. The FIFO storage, the serial shifter, the timeout counter and the register bus all sit outside this block.

Top module: `uart_rx_int_id`

## Requirements
- R1: No receive source is pending unless `fifo_en` is 1 and that source's own enable is 1 (`lsr_int_en` for line status, `rx_int_en` for data available, `tmo_int_en` for timeout).
- R2: Data available is pending when `fifo_count` is at or above the trigger threshold. When the count drops below the threshold, the code moves to the next pending source, or to none.
- R3: `trig_sel` selects the threshold: 2'b00 gives 1 entry, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R4: Line status is pending when `fifo_count` is nonzero and any bit of `head_err` (overrun, parity, framing, break) is 1. It reads as 0xC6 and takes priority over every other source.
- R5: Data available reads as 0xC4 and takes priority over timeout. Timeout reads as 0xCC and is pending only while `tmo_pending` is 1 and `fifo_count` is nonzero.
- R6: With nothing pending, `iir` reads 0xC1, so bit 0 set means no interrupt.
- R7: `irq` is 1 exactly while some enabled source is pending. It falls in the same cycle the last condition clears.
- R8: `id_change` is 1 in any cycle where `iir` differs from the value it had at the previous rising clock edge (0xC1 after reset), and 0 otherwise.
- R9: `data_ready` becomes 1 at the edge after a cycle with `rx_push` high. It becomes 0 at an edge where `fifo_count` is 0 and `rx_push` is low. Otherwise it holds. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | Receive FIFO enabled |
| rx_int_en | input | 1 | Data-available interrupt enable |
| lsr_int_en | input | 1 | Line-status interrupt enable |
| tmo_int_en | input | 1 | Character-timeout interrupt enable |
| trig_sel | input | 2 | Trigger threshold select |
| fifo_count | input | COUNT_W | Current receive FIFO occupancy |
| head_err | input | 4 | Error flags of the head character |
| tmo_pending | input | 1 | Timeout detector's pending flag |
| rx_push | input | 1 | A character is written into the FIFO this cycle |
| iir | output | 8 | Interrupt identification code |
| irq | output | 1 | Level interrupt to the processor |
| id_change | output | 1 | The code differs from its value at the last edge |
| data_ready | output | 1 | Line status data-ready bit |

## Verification
A wrong priority or threshold shows up at once as a wrong `iir` code in the same cycle the inputs change. A bad enable gate does the same, and `irq` then disagrees with `iir` bit 0. The held code is the only hidden state on the interrupt path. If it is corrupt, `id_change` is wrong in the first cycle after a code transition, or it pulses while the code is steady. A stuck or wrongly updated data-ready flop appears one edge after a push, or one edge after the FIFO reports empty.

// File: rtl/uart_rx_int_pkg.sv
package uart_rx_int_pkg;

  localparam logic [7:0] IIR_NONE = 8'hC1;
  localparam logic [7:0] IIR_LSR  = 8'hC6;
  localparam logic [7:0] IIR_RDA  = 8'hC4;
  localparam logic [7:0] IIR_TMO  = 8'hCC;

  typedef struct packed {
    logic line_err;
    logic data_avail;
    logic timeout;
  } rx_pend_t;

  function automatic logic [3:0] trig_threshold(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd1;
      2'b01:   return 4'd4;
      2'b10:   return 4'd8;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic [7:0] encode_iir(input rx_pend_t p);
    if (p.line_err)        return IIR_LSR;
    else if (p.data_avail) return IIR_RDA;
    else if (p.timeout)    return IIR_TMO;
    else                   return IIR_NONE;
  endfunction

endpackage

// File: rtl/rxint_trigger_cmp.sv
module rxint_trigger_cmp
  import uart_rx_int_pkg::*;
#(
  parameter int COUNT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         trig_sel,
  input  logic [COUNT_W-1:0] fifo_count,
  output logic               at_trigger
);

  localparam int THR_W = 4;

  logic [THR_W-1:0]   thr;
  logic [COUNT_W-1:0] thr_ext;

  always_comb begin
    thr        = trig_threshold(trig_sel);
    thr_ext    = COUNT_W'(thr);
    at_trigger = (fifo_count >= thr_ext);
  end

  // every threshold is at least one entry, so an empty FIFO never triggers
  p_trig_nonempty_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    at_trigger |-> (fifo_count != '0));

endmodule

// File: rtl/rxint_dready.sv
module rxint_dready #(
  parameter int COUNT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_push,
  input  logic [COUNT_W-1:0] fifo_count,
  output logic               data_ready
);

  logic fifo_empty;
  logic dr_q;

  assign fifo_empty = (fifo_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dr_q <= 1'b0;
    else if (rx_push)    dr_q <= 1'b1;
    else if (fifo_empty) dr_q <= 1'b0;
  end

  assign data_ready = dr_q;

  p_dr_rise_push_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(rx_push));

  p_dr_clear_empty_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !rx_push) |=> !data_ready);

endmodule

// File: rtl/rxint_prio.sv
module rxint_prio
  import uart_rx_int_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rx_pend_t pend,
  output logic [7:0] code,
  output logic     any_pend
);

  always_comb begin
    code     = encode_iir(pend);
    any_pend = pend.line_err | pend.data_avail | pend.timeout;
  end

  p_lsr_first_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    pend.line_err |-> (code == IIR_LSR));

  p_rda_over_tmo_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend.data_avail && !pend.line_err) |-> (code == IIR_RDA));

endmodule

// File: rtl/uart_rx_int_id.sv
module uart_rx_int_id
  import uart_rx_int_pkg::*;
#(
  parameter int COUNT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               rx_int_en,
  input  logic               lsr_int_en,
  input  logic               tmo_int_en,
  input  logic [1:0]         trig_sel,
  input  logic [COUNT_W-1:0] fifo_count,
  input  logic [3:0]         head_err,
  input  logic               tmo_pending,
  input  logic               rx_push,
  output logic [7:0]         iir,
  output logic               irq,
  output logic               id_change,
  output logic               data_ready
);

  logic     at_trigger;
  logic     has_char;
  logic     head_bad;
  rx_pend_t pend;
  logic [7:0] code;
  logic     any_pend;
  logic [7:0] code_q;

  rxint_trigger_cmp #(.COUNT_W(COUNT_W)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_sel   (trig_sel),
    .fifo_count (fifo_count),
    .at_trigger (at_trigger)
  );

  assign has_char = (fifo_count != '0);
  assign head_bad = has_char && (|head_err);

  always_comb begin
    pend.line_err   = fifo_en && lsr_int_en && head_bad;
    pend.data_avail = fifo_en && rx_int_en  && at_trigger;
    pend.timeout    = fifo_en && tmo_int_en && tmo_pending && has_char;
  end

  rxint_prio u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .code     (code),
    .any_pend (any_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= IIR_NONE;
    else        code_q <= code;
  end

  assign iir       = code;
  assign irq       = any_pend;
  assign id_change = (code != code_q);

  rxint_dready #(.COUNT_W(COUNT_W)) u_dr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_push    (rx_push),
    .fifo_count (fifo_count),
    .data_ready (data_ready)
  );

  p_irq_level_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);

  p_gate_fifo_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (iir == IIR_NONE && !irq));

  p_tmo_needs_char_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |-> (iir == IIR_NONE));

endmodule

// File: tb/test_uart_rx_int_id.sv
module test_uart_rx_int_id;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 0, rx_int_en = 0, lsr_int_en = 0, tmo_int_en = 0;
  logic [1:0]    trig_sel = 0;
  logic [CW-1:0] fifo_count = 0;
  logic [3:0]    head_err = 0;
  logic          tmo_pending = 0, rx_push = 0;
  logic [7:0]    iir;
  logic          irq, id_change, data_ready;

  int total = 0;
  int bad = 0;
  logic [7:0] prev_exp = 8'hC1;

  always #5 clk = ~clk;

  uart_rx_int_id #(.COUNT_W(CW)) i_uart_rx_int_id (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_int_en(rx_int_en),
    .lsr_int_en(lsr_int_en), .tmo_int_en(tmo_int_en), .trig_sel(trig_sel),
    .fifo_count(fifo_count), .head_err(head_err), .tmo_pending(tmo_pending),
    .rx_push(rx_push), .iir(iir), .irq(irq), .id_change(id_change),
    .data_ready(data_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // threshold restated arithmetically: 1,4,8,14
  function automatic int thr_of(input int s);
    return (s == 0) ? 1 : 4 * s + ((s == 3) ? 2 : 0);
  endfunction

  function automatic logic [7:0] model(input int en, input int s, input int c,
                                       input int e, input int t);
    bit f, r, l, m;
    f = en[0]; r = en[1]; l = en[2]; m = en[3];
    if (f && l && c > 0 && e != 0) return 8'hC6;
    if (f && r && c >= thr_of(s))  return 8'hC4;
    if (f && m && t != 0 && c > 0) return 8'hCC;
    return 8'hC1;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R6 reset iir", iir, 8'hC1);
    chk("R7 reset irq", irq, 0);
    chk("R8 reset id_change", id_change, 0);
    chk("R9 reset data_ready", data_ready, 0);

    // sweep over enables, trigger selects, counts, errors and timeout flag (R1..R8)
    for (int en = 0; en < 16; en++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c <= 16; c++)
          for (int ev = 0; ev < 2; ev++)
            for (int t = 0; t < 2; t++) begin
              @(negedge clk);
              {tmo_int_en, lsr_int_en, rx_int_en, fifo_en} = 4'(en);
              trig_sel    = 2'(s);
              fifo_count  = CW'(c);
              head_err    = ev ? (4'b0001 << (c % 4)) : 4'b0;
              tmo_pending = 1'(t);
              #1;
              e = model(en, s, c, ev, t);
              if (en[0] == 0)         chk("R1 iir", iir, e);
              else if (e == 8'hC6)    chk("R4 iir", iir, e);
              else if (e == 8'hC4)    chk("R2 R3 iir", iir, e);
              else if (e == 8'hCC)    chk("R5 iir", iir, e);
              else                    chk("R6 iir", iir, e);
              chk("R7 irq", irq, (e != 8'hC1));
              chk("R8 id_change", id_change, (e != prev_exp));
              @(posedge clk);
              prev_exp = e;
              #1;
              chk("R8 id_change after edge", id_change, 0);
            end

    // falling below trigger moves to timeout, then to none (R2)
    @(negedge clk);
    {tmo_int_en, lsr_int_en, rx_int_en, fifo_en} = 4'b1011;
    trig_sel = 2'b01; fifo_count = 5; head_err = 0; tmo_pending = 1;
    #1 chk("R2 above trigger", iir, 8'hC4);
    @(negedge clk) fifo_count = 3;
    #1 chk("R2 below trigger next source", iir, 8'hCC);
    chk("R8 change on drop", id_change, 1);
    @(negedge clk) tmo_pending = 0;
    #1 chk("R7 irq falls same cycle", irq, 0);
    chk("R2 none left", iir, 8'hC1);

    // data-ready behaviour (R9)
    @(negedge clk) fifo_count = 0; rx_push = 0;
    @(negedge clk) chk("R9 idle empty", data_ready, 0);
    rx_push = 1;
    @(negedge clk) chk("R9 set after push", data_ready, 1);
    rx_push = 0; fifo_count = 3;
    @(negedge clk) chk("R9 holds nonempty", data_ready, 1);
    @(negedge clk) chk("R9 still holds", data_ready, 1);
    fifo_count = 0;
    @(negedge clk) chk("R9 cleared on empty", data_ready, 0);
    rx_push = 1;
    @(negedge clk) chk("R9 push beats empty", data_ready, 1);
    rx_push = 0;
    @(negedge clk) chk("R9 clears again", data_ready, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule